// File: doc/BRIEF.md
# TDM Time-Slot Interchanger with Selectable Delay Mode

This block switches bytes between time-slots of one framed TDM link. Each frame holds 32, 64 or 128 channels of 8 bits, chosen by a 2-bit rate field. One byte enters on each slot strobe. A connection map names, for every output slot, the input channel that it carries. The output byte is registered and appears one clock after its slot strobe.

A mode bit selects one of two behaviours. In variable-delay mode there is a single data bank that is written and read in the same frame, so each output slot gets the freshest copy of its source channel. In constant-delay mode three banks rotate once per frame. A byte that enters in frame N always leaves in frame N+2, whatever the slot pairing, so frame order is kept intact.

Map writes, the rate field and the mode bit all go to a pending copy. That copy takes effect at the next frame boundary, so one frame never mixes two settings.

Top module: `tsi_switch`

## Requirements
- R1: After synchronous reset, `dout_o` is 0 and `dout_vld_o` is 0. Every data-bank byte and every map entry is 0. The mode is variable-delay and the frame has 32 slots.
- R2: `dout_vld_o` is 1 exactly in the clock after a cycle with `slot_en_i` high. `dout_o` changes only in that clock and holds its value otherwise.
- R3: A strobe that carries `frame_sync_i` is slot 0 of a new frame. Later strobes are numbered 1, 2, and so on. If frame sync is absent, the strobe after slot S-1 starts a new frame by itself. S is 32 for rate 0, 64 for rate 1, and 128 for rates 2 and 3.
- R4: Output slot j carries the stored byte of the input channel that map entry j names. Map entries hold 0-based slot numbers.
- R5: In variable-delay mode, when map entry j names channel k, output slot j takes a byte from input channel k. If k < j, the byte is the one received in the current frame. If k ≥ j, it is the one received in the previous frame.
- R6: In constant-delay mode, a byte received in slot IN of frame N leaves in its mapped slot OUT of frame N+2. Slots are numbered from 1. The number of strobes strictly between the input strobe and the output strobe is S + (S − IN) + (OUT − 1). For S = 32 this ranges from 32 (IN 32 to OUT 1) to 94 (IN 1 to OUT 32).
- R7: A map write made during a frame does not change that frame's output. It applies from the next frame boundary on.
- R8: The mode bit and the rate field are sampled only at a frame boundary. When the mode changes at a boundary, the bank rotation restarts at bank 0.
- R9: Cycles with `slot_en_i` low store nothing, do not advance the slot count and do not change `dout_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync_i | input | 1 | Marks the strobe that begins a frame |
| slot_en_i | input | 1 | Slot strobe, one byte per strobe |
| din_i | input | DATA_W | Byte for the current input slot |
| rate_sel_i | input | 2 | Frame size select, 0:32, 1:64, 2/3:128 slots |
| const_mode_i | input | 1 | 1 = constant-delay, 0 = variable-delay |
| map_wr_i | input | 1 | Connection-map write strobe |
| map_addr_i | input | SLOT_W | Output slot whose entry is written |
| map_src_i | input | SLOT_W | Input channel for that output slot |
| dout_o | output | DATA_W | Switched byte, registered |
| dout_vld_o | output | 1 | High one clock after each slot strobe |

## Verification
The switch is driven with a scattered map, (7j+3) mod 32, and with a full reversal. The scattered map mixes sources before and after their output slot, so it separates current-frame data from previous-frame data in variable mode. The reversal, together with two marker bytes, measures the extreme strobe distances of 94 and 32 in constant mode. Mid-frame map writes and mid-frame changes of mode and rate show whether anything takes effect before the boundary. A frame with no sync pulse checks the self-timed wrap at 128 slots, and idle cycles with random input bytes show that unstrobed data never reaches the banks.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int NUM_BANKS = 3;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    typedef enum logic {
        MODE_VAR   = 1'b0,
        MODE_CONST = 1'b1
    } delay_mode_e;

    typedef struct packed {
        logic [1:0]  rate;
        delay_mode_e mode;
    } frame_cfg_t;

    // slots per frame for a rate code, clipped to the storage depth
    function automatic int slots_for_rate(logic [1:0] rate, int max_slots);
        int n;
        case (rate)
            2'd0:    n = 32;
            2'd1:    n = 64;
            default: n = 128;
        endcase
        return (n > max_slots) ? max_slots : n;
    endfunction

    function automatic logic [BANK_W-1:0] bank_succ(logic [BANK_W-1:0] b);
        return (b == BANK_W'(NUM_BANKS - 1)) ? '0 : b + 1'b1;
    endfunction

endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
    import tsi_pkg::*;
#(
    parameter int MAX_SLOTS = 128,
    localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  slot_en_i,
    input  logic                  fs_i,
    input  frame_cfg_t            cfg_i,
    output logic                  bnd_o,
    output logic [SLOT_W-1:0]     slot_o,
    output logic [BANK_W-1:0]     wr_bank_o,
    output logic [BANK_W-1:0]     rd_bank_o,
    output logic                  const_o
);

    logic [SLOT_W:0]   nxt_q;
    logic [BANK_W-1:0] bank_q;
    frame_cfg_t        cfg_q;

    logic [SLOT_W:0]   lim;
    frame_cfg_t        cfg_eff;
    logic [BANK_W-1:0] bank_eff;

    always_comb begin
        lim     = (SLOT_W+1)'(slots_for_rate(cfg_q.rate, MAX_SLOTS));
        bnd_o   = slot_en_i && (fs_i || (nxt_q >= lim));
        cfg_eff = bnd_o ? cfg_i : cfg_q;
        slot_o  = bnd_o ? '0 : nxt_q[SLOT_W-1:0];
        if (!bnd_o)
            bank_eff = bank_q;
        else if (cfg_i.mode != MODE_CONST || cfg_i.mode != cfg_q.mode)
            bank_eff = '0;
        else
            bank_eff = bank_succ(bank_q);
        const_o   = (cfg_eff.mode == MODE_CONST);
        wr_bank_o = const_o ? bank_eff : '0;
        rd_bank_o = const_o ? bank_succ(bank_eff) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_q  <= '0;
            bank_q <= '0;
            cfg_q  <= '{rate: 2'd0, mode: MODE_VAR};
        end else if (slot_en_i) begin
            nxt_q  <= {1'b0, slot_o} + 1'b1;
            bank_q <= bank_eff;
            cfg_q  <= cfg_eff;
        end
    end

endmodule

// File: rtl/tsi_conn_map.sv
module tsi_conn_map #(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [AW-1:0] wdata_i,
    input  logic          commit_i,
    input  logic [AW-1:0] raddr_i,
    output logic [AW-1:0] rdata_o
);

    logic [AW-1:0] pend_q [DEPTH];
    logic [AW-1:0] live_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                pend_q[i] <= '0;
                live_q[i] <= '0;
            end
        end else begin
            if (commit_i)
                for (int i = 0; i < DEPTH; i++)
                    live_q[i] <= pend_q[i];
            if (wr_i)
                pend_q[waddr_i] <= wdata_i;
        end
    end

    // at the boundary strobe the pending map is already in force
    assign rdata_o = commit_i ? pend_q[raddr_i] : live_q[raddr_i];

endmodule

// File: rtl/tsi_bank_store.sv
module tsi_bank_store
    import tsi_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [BANK_W-1:0] wbank_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BANK_W-1:0] rbank_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] rd_word [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++)
                    mem[i] <= '0;
            end else if (we_i && wbank_i == BANK_W'(b)) begin
                mem[waddr_i] <= wdata_i;
            end
        end

        assign rd_word[b] = mem[raddr_i];
    end

    always_comb begin
        rdata_o = rd_word[0];
        for (int b = 1; b < NUM_BANKS; b++)
            if (rbank_i == BANK_W'(b))
                rdata_o = rd_word[b];
    end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MAX_SLOTS = 128,
    localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync_i,
    input  logic              slot_en_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic [1:0]        rate_sel_i,
    input  logic              const_mode_i,
    input  logic              map_wr_i,
    input  logic [SLOT_W-1:0] map_addr_i,
    input  logic [SLOT_W-1:0] map_src_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_vld_o
);

    frame_cfg_t        cfg_in;
    logic              bnd;
    logic [SLOT_W-1:0] cur_slot;
    logic [BANK_W-1:0] wr_bank;
    logic [BANK_W-1:0] rd_bank;
    logic              is_const;
    logic [SLOT_W-1:0] src_slot;
    logic [DATA_W-1:0] rd_byte;

    assign cfg_in = '{rate: rate_sel_i, mode: delay_mode_e'(const_mode_i)};

    tsi_frame_timer #(.MAX_SLOTS(MAX_SLOTS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .slot_en_i (slot_en_i),
        .fs_i      (frame_sync_i),
        .cfg_i     (cfg_in),
        .bnd_o     (bnd),
        .slot_o    (cur_slot),
        .wr_bank_o (wr_bank),
        .rd_bank_o (rd_bank),
        .const_o   (is_const)
    );

    tsi_conn_map #(.DEPTH(MAX_SLOTS)) u_map (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (map_wr_i),
        .waddr_i  (map_addr_i),
        .wdata_i  (map_src_i),
        .commit_i (bnd),
        .raddr_i  (cur_slot),
        .rdata_o  (src_slot)
    );

    tsi_bank_store #(.DEPTH(MAX_SLOTS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we_i    (slot_en_i),
        .wbank_i (wr_bank),
        .waddr_i (cur_slot),
        .wdata_i (din_i),
        .rbank_i (rd_bank),
        .raddr_i (src_slot),
        .rdata_o (rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_o     <= '0;
            dout_vld_o <= 1'b0;
        end else begin
            dout_vld_o <= slot_en_i;
            if (slot_en_i)
                dout_o <= rd_byte;
        end
    end

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
    parameter int DATA_W = 8,
    parameter int SLOT_W = 7,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              slot_en_i,
    input logic              frame_sync_i,
    input logic [DATA_W-1:0] dout_o,
    input logic              dout_vld_o,
    input logic              bnd,
    input logic [SLOT_W-1:0] cur_slot,
    input logic [BANK_W-1:0] wr_bank,
    input logic [BANK_W-1:0] rd_bank,
    input logic              is_const
);

    assert_vld_follows_R2: assert property (@(posedge clk) disable iff (rst)
        slot_en_i |=> dout_vld_o);

    assert_vld_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !slot_en_i |=> !dout_vld_o);

    assert_dout_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !slot_en_i |=> $stable(dout_o));

    assert_sync_starts_R3: assert property (@(posedge clk) disable iff (rst)
        (slot_en_i && frame_sync_i) |-> (bnd && cur_slot == '0));

    assert_no_idle_boundary_R9: assert property (@(posedge clk) disable iff (rst)
        !slot_en_i |-> !bnd);

    assert_banks_apart_R6: assert property (@(posedge clk) disable iff (rst)
        (slot_en_i && is_const) |-> (wr_bank != rd_bank && wr_bank < 2'd3 && rd_bank < 2'd3));

    assert_single_bank_R5: assert property (@(posedge clk) disable iff (rst)
        (slot_en_i && !is_const) |-> (wr_bank == '0 && rd_bank == '0));

endmodule

bind tsi_switch tsi_switch_chk #(
    .DATA_W (DATA_W),
    .SLOT_W (SLOT_W),
    .BANK_W (tsi_pkg::BANK_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .slot_en_i    (slot_en_i),
    .frame_sync_i (frame_sync_i),
    .dout_o       (dout_o),
    .dout_vld_o   (dout_vld_o),
    .bnd          (bnd),
    .cur_slot     (cur_slot),
    .wr_bank      (wr_bank),
    .rd_bank      (rd_bank),
    .is_const     (is_const)
);

// File: tb/tsi_switch_tb_top.sv
module tsi_switch_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fs  = 1'b0;
    logic       sen = 1'b0;
    logic [7:0] din = 8'd0;
    logic [1:0] rate = 2'd0;
    logic       cmode = 1'b0;
    logic       mw = 1'b0;
    logic [6:0] ma = 7'd0;
    logic [6:0] ms = 7'd0;
    logic [7:0] dout;
    logic       dvld;

    tsi_switch dut_i (
        .clk          (clk),
        .rst          (rst),
        .frame_sync_i (fs),
        .slot_en_i    (sen),
        .din_i        (din),
        .rate_sel_i   (rate),
        .const_mode_i (cmode),
        .map_wr_i     (mw),
        .map_addr_i   (ma),
        .map_src_i    (ms),
        .dout_o       (dout),
        .dout_vld_o   (dvld)
    );

    initial forever #4 clk = ~clk;

    // behavioural reference: byte history per frame, not bank structure
    int         nchk = 0, nbad = 0;
    string      tag = "R1";
    int         m_slot = 0, m_S = 32, m_age = 0, sidx = 0, frno = 0;
    bit         m_const = 1'b0, m_prevvar = 1'b1;
    logic [7:0] h0 [128], h1 [128], h2 [128];
    bit         v0 [128], v1 [128], v2 [128];
    int         map_a [128], map_p [128];
    int         tag_a_in = -1, tag_c_in = -1;
    bit         tag_a_done = 1'b0, tag_c_done = 1'b0;
    bit         want_mode = 1'b0;
    logic [1:0] want_rate = 2'd0;
    bit         finished = 1'b0;

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual=%0h expected=%0h (strobe %0d)", r, act, exp, sidx);
        end
    endtask

    task automatic map_write(input int a, input int s);
        @(negedge clk);
        mw = 1'b1; ma = 7'(a); ms = 7'(s);
        map_p[a] = s;
        @(negedge clk);
        mw = 1'b0;
    endtask

    task automatic do_slot(input bit f, input logic [7:0] d);
        int src;
        bit ok;
        logic [7:0] exp_d;
        logic [7:0] held;
        @(negedge clk);
        sen = 1'b1; fs = f; din = d;
        if (f || m_slot >= m_S) begin
            h2 = h1; v2 = v1; h1 = h0; v1 = v0;
            for (int i = 0; i < 128; i++) v0[i] = 1'b0;
            m_prevvar = !m_const;
            if (cmode && !m_const) m_age = 0;
            else if (cmode) m_age++;
            m_const = cmode;
            m_S = (rate == 2'd0) ? 32 : (rate == 2'd1) ? 64 : 128;
            map_a = map_p;
            m_slot = 0;
            frno++;
        end
        src = map_a[m_slot];
        ok = 1'b0;
        exp_d = 8'd0;
        if (m_const) begin
            if (m_age >= 2 && v2[src]) begin ok = 1'b1; exp_d = h2[src]; end
        end else if (src < m_slot) begin
            ok = 1'b1; exp_d = h0[src];
        end else if (m_prevvar && v1[src]) begin
            ok = 1'b1; exp_d = h1[src];
        end
        h0[m_slot] = d; v0[m_slot] = 1'b1;
        if (m_const && d == 8'hA5) tag_a_in = sidx;
        if (m_const && d == 8'hC3) tag_c_in = sidx;
        m_slot++;
        @(negedge clk);
        sen = 1'b0; fs = 1'b0; din = 8'($urandom);
        check("R2 valid after strobe", {31'd0, dvld}, 32'd1);
        if (ok) check(tag, {24'd0, dout}, {24'd0, exp_d});
        // R6 strobe distance: IN 1 -> OUT 32 gives 94, IN 32 -> OUT 1 gives 32
        if (dout == 8'hA5 && tag_a_in >= 0 && !tag_a_done) begin
            tag_a_done = 1'b1;
            check("R6 delay IN1->OUT32", sidx - tag_a_in - 1, 94);
        end
        if (dout == 8'hC3 && tag_c_in >= 0 && !tag_c_done) begin
            tag_c_done = 1'b1;
            check("R6 delay IN32->OUT1", sidx - tag_c_in - 1, 32);
        end
        held = dout;
        sidx++;
        @(negedge clk);
        check("R2 valid low when idle", {31'd0, dvld}, 32'd0);
        check("R9 output held when idle", {24'd0, dout}, {24'd0, held});
    endtask

    task automatic run_frame(input bit wfs, input bit tags, input bit midwrite);
        int n;
        do_slot(wfs, tags ? 8'hA5 : {1'b0, 7'(frno * 13)});
        n = m_S;
        for (int s = 1; s < n; s++) begin
            if (s == 5) begin
                cmode = want_mode;
                rate  = want_rate;
            end
            if (midwrite && s == 10)
                for (int j = 0; j < 32; j++) map_write(j, 31 - j);
            if (tags && s == n - 1) do_slot(1'b0, 8'hC3);
            else do_slot(1'b0, {1'b0, 7'(frno * 13 + s * 3)});
        end
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            h0[i] = 8'd0; h1[i] = 8'd0; h2[i] = 8'd0;
            v0[i] = 1'b1; v1[i] = 1'b1; v2[i] = 1'b0;
            map_a[i] = 0; map_p[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1 dout after reset", {24'd0, dout}, 32'd0);
        check("R1 valid after reset", {31'd0, dvld}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        for (int j = 0; j < 32; j++) map_write(j, (j * 7 + 3) % 32);

        tag = "R1 zeroed banks";    run_frame(1'b1, 1'b0, 1'b0);
        tag = "R4 mapped output";   run_frame(1'b1, 1'b0, 1'b0);
        tag = "R5 variable mode";   run_frame(1'b1, 1'b0, 1'b0);
        tag = "R7 mid-frame map";   run_frame(1'b1, 1'b0, 1'b1);
        tag = "R7 map at boundary"; run_frame(1'b1, 1'b0, 1'b0);
        want_mode = 1'b1;
        tag = "R8 mode mid-frame";  run_frame(1'b1, 1'b0, 1'b0);
        tag = "R6 constant mode";
        run_frame(1'b1, 1'b0, 1'b0);
        run_frame(1'b1, 1'b1, 1'b0);
        run_frame(1'b1, 1'b0, 1'b0);
        run_frame(1'b1, 1'b0, 1'b0);
        want_rate = 2'd1;
        tag = "R8 rate mid-frame";  run_frame(1'b1, 1'b0, 1'b0);
        tag = "R6 constant 64";
        for (int k = 0; k < 3; k++) run_frame(1'b1, 1'b0, 1'b0);
        want_rate = 2'd2; want_mode = 1'b0;
        tag = "R8 mode back";       run_frame(1'b1, 1'b0, 1'b0);
        tag = "R5 variable 128";
        run_frame(1'b1, 1'b0, 1'b0);
        run_frame(1'b1, 1'b0, 1'b0);
        tag = "R3 self-timed frame"; run_frame(1'b0, 1'b0, 1'b0);
        want_rate = 2'd3;
        tag = "R3 after wrap";      run_frame(1'b1, 1'b0, 1'b0);
        tag = "R3 rate code 3";     run_frame(1'b1, 1'b0, 1'b0);
        check("R6 marker A5 seen", {31'd0, tag_a_done}, 32'd1);
        check("R6 marker C3 seen", {31'd0, tag_c_done}, 32'd1);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++; nbad++;
            $display("FAIL watchdog R2: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule